// File: doc/BRIEF.md
# Duty-Cycled Receiver Wake-Up Controller

This block keeps a radio receiver asleep most of the time. At a fixed interval it wakes the receiver briefly to check whether a frequency-shift-keyed transmission is on the air. Both the interval and the listening time are counted on a prescaled tick input. The interval comes from an 8-bit period setting. The listening time comes from a 7-bit duty setting, so the on-time fraction is (2·duty + 1) / period. Each wake begins with a programmable oscillator start-up count. During that count the oscillator runs but the receive path stays off.

If the data-quality indicator goes high during the listening part of a window, the window no longer ends on its own. It stays open while the indicator stays high. The block raises an interrupt to the host and stores each received bit in a small receive FIFO. The window closes when the indicator drops or when the host pulses a FIFO-done input. The block then powers down the oscillator and the receive path and clears the interrupt. The FIFO keeps its data so the host can read it while the receiver sleeps.

Top module: `rxwake_ctrl`

## Requirements
- R1: The block cycles only while `wake_en` is 1 and `cont_rx` is 0. With any other combination, `osc_en`, `rx_en` and `irq` are low from the cycle after the change, and they stay low across ticks.
- R2: The period P is `period_cfg`, raised to 2 if the setting is below 2. The first window opens in the clock cycle after the mode becomes legal. A new window then opens every P ticks.
- R3: The base on-time T is 2·`duty_cfg` + 1 ticks, lowered to P − 1 if that is not less than P. Counting m ticks from the start of a window, with `dqi` low, `osc_en` is 1 exactly when m mod P < T.
- R4: With S = `start_cfg`, `rx_en` is 1 exactly when S ≤ (m mod P) < T. If S ≥ T, the receive path never turns on in that window.
- R5: If `dqi` is high in a clock cycle while `rx_en` is high and the window is not yet extended, the window becomes extended and `irq` rises in the next cycle. While `dqi` stays high, `osc_en` and `rx_en` stay high regardless of ticks.
- R6: In an extended window, `dqi` low or a `fifo_done` pulse closes the window in the next cycle, and `osc_en`, `rx_en` and `irq` all drop. The next window opens after exactly P − T further ticks.
- R7: A `bit_valid` strobe writes `bit_data` into the FIFO only in an extended window. Strobes during start-up, in the base window or during sleep store nothing. Bits read out in arrival order: `rd_data` shows the oldest bit and a `fifo_pop` pulse removes it. A pop when `fifo_empty` is 1 is ignored.
- R8: A write when the FIFO already holds FIFO_DEPTH bits (default 8) is dropped and the stored bits do not change. The write sets `overflow`, which then stays 1 until reset.
- R9: After reset, `osc_en`, `rx_en`, `irq` and `overflow` are 0 and `fifo_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescaled timing strobe, one cycle wide |
| wake_en | input | 1 | Wake-up timer enable |
| cont_rx | input | 1 | Continuous-receive enable; blocks duty cycling when 1 |
| period_cfg | input | 8 | Wake-up period in ticks |
| duty_cfg | input | 7 | Duty setting; base on-time is 2·duty+1 ticks |
| start_cfg | input | 4 | Oscillator start-up ticks at each wake |
| dqi | input | 1 | Data-quality indicator from the demodulator |
| bit_valid | input | 1 | Received-bit strobe |
| bit_data | input | 1 | Received bit value |
| fifo_done | input | 1 | Host pulse: reading finished, return to sleep |
| fifo_pop | input | 1 | Host pulse: remove oldest FIFO bit |
| osc_en | output | 1 | Oscillator and synthesizer enable |
| rx_en | output | 1 | Receive chain enable |
| irq | output | 1 | Interrupt to host: valid data present |
| rd_data | output | 1 | Oldest bit in the FIFO |
| fifo_empty | output | 1 | FIFO holds no bits |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH bits |
| overflow | output | 1 | Sticky: a write was dropped because the FIFO was full |

## Verification
Every result is registered once. A tick, a `dqi` change, a `fifo_done` pulse, a mode change or a FIFO strobe seen at one rising edge shows up at the outputs just after that edge. The bench drives each stimulus for exactly one edge and samples on the falling edge that follows. Window checks count ticks, not clock cycles. One sweep covers periods from 0 to 8, several duty settings and start-up counts of 0, 1 and 3. For each combination it predicts `osc_en` and `rx_en` for every tick of two full periods from m mod P, T and S. The sleep gap after an extended window is checked one tick before and at tick P − T.

// File: rtl/rxwake_pkg.sv
// Package: shared types and defaults for the receiver wake-up controller.
// Assumes: nothing beyond IEEE 1800-2017.
package rxwake_pkg;

    // Sequencer states; OFF is the state held while the mode is illegal.
    typedef enum logic [2:0] {
        WK_OFF    = 3'd0,
        WK_SLEEP  = 3'd1,
        WK_START  = 3'd2,
        WK_LISTEN = 3'd3,
        WK_HOLD   = 3'd4
    } wake_state_t;

    localparam int unsigned DEF_PERIOD_W = 8;
    localparam int unsigned DEF_START_W  = 4;
    localparam int unsigned DEF_DEPTH    = 8;

endpackage

// File: rtl/rxwake_timing.sv
// Module: rxwake_timing
// Turns the raw period and duty settings into the working period length and
// base on-time, in ticks. The period is at least 2. The on-time is 2*duty+1,
// lowered to period-1 so that every period has at least one sleep tick.
// Assumes: settings are static while the block is cycling.
module rxwake_timing #(
    parameter int unsigned PERIOD_W = 8,
    localparam int unsigned DUTY_W  = PERIOD_W - 1
) (
    input  logic [PERIOD_W-1:0] period_cfg,
    input  logic [DUTY_W-1:0]   duty_cfg,
    output logic [PERIOD_W-1:0] p_len,
    output logic [PERIOD_W-1:0] t_on
);

    logic [PERIOD_W-1:0] base_on;

    // Derive the clamped period and the clamped on-time.
    always_comb begin
        p_len   = (period_cfg < PERIOD_W'(2)) ? PERIOD_W'(2) : period_cfg;
        base_on = {duty_cfg, 1'b1};
        t_on    = (base_on >= p_len) ? (p_len - PERIOD_W'(1)) : base_on;
    end

endmodule

// File: rtl/rxwake_seq.sv
// Module: rxwake_seq
// Sleep / start-up / listen / hold sequencer. One period counter runs on the
// tick strobe. It is frozen while the window is held open by a good
// data-quality indicator. Leaving the hold state sets the counter to the end
// of the base window, so the following sleep keeps its normal length.
// Assumes: tick is a single-cycle strobe; dqi is synchronous to clk.
module rxwake_seq #(
    parameter int unsigned PERIOD_W = 8,
    parameter int unsigned START_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                mode_ok,
    input  logic [PERIOD_W-1:0] p_len,
    input  logic [PERIOD_W-1:0] t_on,
    input  logic [START_W-1:0]  start_cfg,
    input  logic                dqi,
    input  logic                fifo_done,
    input  logic                bit_valid,
    output logic                osc_en,
    output logic                rx_en,
    output logic                irq,
    output logic                push
);
    import rxwake_pkg::*;

    wake_state_t         state;
    logic [PERIOD_W-1:0] pcnt;
    logic [START_W-1:0]  scnt;
    logic [PERIOD_W:0]   pcnt_nx;
    logic [START_W:0]    scnt_nx;
    logic                win_end;
    logic                start_end;
    logic                wrap;
    wake_state_t         wake_tgt;

    // Next-count values and the decisions taken on a tick.
    always_comb begin
        pcnt_nx   = {1'b0, pcnt} + (PERIOD_W+1)'(1);
        scnt_nx   = {1'b0, scnt} + (START_W+1)'(1);
        win_end   = pcnt_nx >= {1'b0, t_on};
        start_end = scnt_nx >= {1'b0, start_cfg};
        wrap      = pcnt >= (p_len - PERIOD_W'(1));
        wake_tgt  = (start_cfg == '0) ? WK_LISTEN : WK_START;
    end

    // State, period counter, start-up counter and interrupt register.
    always_ff @(posedge clk) begin
        if (!rst_n || !mode_ok) begin
            state <= WK_OFF;
            pcnt  <= '0;
            scnt  <= '0;
            irq   <= 1'b0;
        end else begin
            case (state)
                WK_OFF: begin
                    pcnt  <= '0;
                    scnt  <= '0;
                    state <= wake_tgt;
                end
                WK_SLEEP: begin
                    if (tick) begin
                        if (wrap) begin
                            pcnt  <= '0;
                            scnt  <= '0;
                            state <= wake_tgt;
                        end else begin
                            pcnt <= pcnt_nx[PERIOD_W-1:0];
                        end
                    end
                end
                WK_START: begin
                    if (tick) begin
                        pcnt <= pcnt_nx[PERIOD_W-1:0];
                        scnt <= scnt_nx[START_W-1:0];
                        if (win_end)
                            state <= WK_SLEEP;
                        else if (start_end)
                            state <= WK_LISTEN;
                    end
                end
                WK_LISTEN: begin
                    if (dqi) begin
                        state <= WK_HOLD;
                        irq   <= 1'b1;
                    end else if (tick) begin
                        pcnt <= pcnt_nx[PERIOD_W-1:0];
                        if (win_end)
                            state <= WK_SLEEP;
                    end
                end
                WK_HOLD: begin
                    if (!dqi || fifo_done) begin
                        state <= WK_SLEEP;
                        irq   <= 1'b0;
                        pcnt  <= t_on;
                    end
                end
                default: state <= WK_OFF;
            endcase
        end
    end

    // Decode the power enables and the FIFO write strobe from the state.
    always_comb begin
        osc_en = (state == WK_START) || (state == WK_LISTEN) || (state == WK_HOLD);
        rx_en  = (state == WK_LISTEN) || (state == WK_HOLD);
        push   = bit_valid && (state == WK_HOLD);
    end

    // R1
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok |=> (!osc_en && !irq));

    // R5
    hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ok && state == WK_LISTEN && dqi) |=> (state == WK_HOLD && irq));

    // R6
    hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ok && state == WK_HOLD && (!dqi || fifo_done)) |=> (state == WK_SLEEP && !irq && !osc_en));

endmodule

// File: rtl/rxwake_fifo.sv
// Module: rxwake_fifo
// Synchronous show-ahead FIFO for received bits. A write when the FIFO is
// full is dropped and sets a sticky overflow flag. A read when empty is
// ignored.
// Assumes: DEPTH is a power of two, at least 2.
module rxwake_fifo #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic din,
    input  logic pop,
    output logic dout,
    output logic empty,
    output logic full,
    output logic ovf
);

    logic [DEPTH-1:0] mem;
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [AW:0]      count;
    logic             wr_ok;
    logic             rd_ok;

    // Flags and accepted-operation strobes.
    always_comb begin
        empty = (count == '0);
        full  = (count == (AW+1)'(DEPTH));
        wr_ok = push && !full;
        rd_ok = pop && !empty;
        dout  = mem[rd_ptr];
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mem <= '0;
        else if (wr_ok)
            mem[wr_ptr] <= din;
    end

    // Pointers, occupancy and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + AW'(1);
            if (rd_ok) rd_ptr <= rd_ptr + AW'(1);
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + (AW+1)'(1);
                2'b01:   count <= count - (AW+1)'(1);
                default: count <= count;
            endcase
            if (push && full) ovf <= 1'b1;
        end
    end

    // R8
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(ovf));

    // R7
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);

endmodule

// File: rtl/rxwake_ctrl.sv
// Module: rxwake_ctrl (top)
// Duty-cycled receiver wake-up controller. Applies the mode rule
// (wake timer on, continuous receive off), derives the period and on-time,
// sequences the receiver power and buffers received bits for the host.
// Assumes: configuration is changed only while the mode is illegal.
module rxwake_ctrl #(
    parameter int unsigned PERIOD_W   = rxwake_pkg::DEF_PERIOD_W,
    parameter int unsigned START_W    = rxwake_pkg::DEF_START_W,
    parameter int unsigned FIFO_DEPTH = rxwake_pkg::DEF_DEPTH,
    localparam int unsigned DUTY_W    = PERIOD_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wake_en,
    input  logic                cont_rx,
    input  logic [PERIOD_W-1:0] period_cfg,
    input  logic [DUTY_W-1:0]   duty_cfg,
    input  logic [START_W-1:0]  start_cfg,
    input  logic                dqi,
    input  logic                bit_valid,
    input  logic                bit_data,
    input  logic                fifo_done,
    input  logic                fifo_pop,
    output logic                osc_en,
    output logic                rx_en,
    output logic                irq,
    output logic                rd_data,
    output logic                fifo_empty,
    output logic                fifo_full,
    output logic                overflow
);

    logic                mode_ok;
    logic [PERIOD_W-1:0] p_len;
    logic [PERIOD_W-1:0] t_on;
    logic                push;

    // Duty cycling is legal only with the timer on and continuous receive off.
    always_comb mode_ok = wake_en && !cont_rx;

    rxwake_timing #(.PERIOD_W(PERIOD_W)) u_timing (
        .period_cfg (period_cfg),
        .duty_cfg   (duty_cfg),
        .p_len      (p_len),
        .t_on       (t_on)
    );

    rxwake_seq #(.PERIOD_W(PERIOD_W), .START_W(START_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode_ok   (mode_ok),
        .p_len     (p_len),
        .t_on      (t_on),
        .start_cfg (start_cfg),
        .dqi       (dqi),
        .fifo_done (fifo_done),
        .bit_valid (bit_valid),
        .osc_en    (osc_en),
        .rx_en     (rx_en),
        .irq       (irq),
        .push      (push)
    );

    rxwake_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (bit_data),
        .pop   (fifo_pop),
        .dout  (rd_data),
        .empty (fifo_empty),
        .full  (fifo_full),
        .ovf   (overflow)
    );

endmodule

// File: tb/rxwake_ctrl_tb.sv
// Bench for rxwake_ctrl: sweeps period, duty and start-up settings with
// arithmetic expectations, then runs the extension, FIFO and overflow cases.
module rxwake_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wake_en = 1'b0;
    logic       cont_rx = 1'b0;
    logic [7:0] period_cfg = 8'd0;
    logic [6:0] duty_cfg = 7'd0;
    logic [3:0] start_cfg = 4'd0;
    logic       dqi = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_data = 1'b0;
    logic       fifo_done = 1'b0;
    logic       fifo_pop = 1'b0;
    logic       osc_en, rx_en, irq, rd_data, fifo_empty, fifo_full, overflow;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rxwake_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wake_en(wake_en), .cont_rx(cont_rx),
        .period_cfg(period_cfg), .duty_cfg(duty_cfg), .start_cfg(start_cfg),
        .dqi(dqi), .bit_valid(bit_valid), .bit_data(bit_data),
        .fifo_done(fifo_done), .fifo_pop(fifo_pop),
        .osc_en(osc_en), .rx_en(rx_en), .irq(irq), .rd_data(rd_data),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .overflow(overflow)
    );

    task automatic chk(input int act, input int exp, input string what);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic v);
        bit_valid = 1'b1;
        bit_data  = v;
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic pop_bit(input logic exp, input string what);
        chk(int'(rd_data), int'(exp), what);
        fifo_pop = 1'b1;
        @(negedge clk);
        fifo_pop = 1'b0;
    endtask

    task automatic go_off();
        wake_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic go_on();
        wake_en = 1'b1;
        @(negedge clk);
    endtask

    function automatic int pick_per(input int i);
        case (i)
            0: return 0;  1: return 1;  2: return 2;
            3: return 3;  4: return 5;  default: return 8;
        endcase
    endfunction

    function automatic int pick_duty(input int i);
        case (i)
            0: return 0;  1: return 1;  2: return 2;  default: return 4;
        endcase
    endfunction

    function automatic int pick_st(input int i);
        case (i)
            0: return 0;  1: return 1;  default: return 3;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] pat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(int'(osc_en), 0, "R9 osc_en");
        chk(int'(rx_en), 0, "R9 rx_en");
        chk(int'(irq), 0, "R9 irq");
        chk(int'(overflow), 0, "R9 overflow");
        chk(int'(fifo_empty), 1, "R9 fifo_empty");

        // R1: continuous receive on blocks cycling
        cont_rx = 1'b1;
        period_cfg = 8'd4; duty_cfg = 7'd0; start_cfg = 4'd0;
        go_on();
        for (int i = 0; i < 5; i++) begin
            chk(int'(osc_en), 0, "R1 osc_en with cont_rx");
            do_tick();
        end
        cont_rx = 1'b0;
        @(negedge clk);
        chk(int'(osc_en), 1, "R1 window opens once legal");
        cont_rx = 1'b1;
        @(negedge clk);
        chk(int'(osc_en), 0, "R1 osc_en off after cont_rx set");
        chk(int'(rx_en), 0, "R1 rx_en off after cont_rx set");
        cont_rx = 1'b0;
        go_off();

        // R2 R3 R4 sweep
        for (int pi = 0; pi < 6; pi++) begin
            for (int di = 0; di < 4; di++) begin
                for (int si = 0; si < 3; si++) begin
                    int p, t, s, m;
                    p = pick_per(pi); if (p < 2) p = 2;
                    t = 2 * pick_duty(di) + 1; if (t >= p) t = p - 1;
                    s = pick_st(si);
                    period_cfg = 8'(pick_per(pi));
                    duty_cfg   = 7'(pick_duty(di));
                    start_cfg  = 4'(s);
                    go_on();
                    for (int k = 0; k <= 2 * p; k++) begin
                        m = k % p;
                        chk(int'(osc_en), (m < t) ? 1 : 0, "R2 R3 osc_en per tick");
                        chk(int'(rx_en), (m >= s && m < t) ? 1 : 0, "R4 rx_en per tick");
                        do_tick();
                    end
                    go_off();
                    chk(int'(osc_en), 0, "R1 osc_en after disable");
                end
            end
        end

        // R5 R6 R7: extended window, P=10, T=3, S=1
        period_cfg = 8'd10; duty_cfg = 7'd1; start_cfg = 4'd1;
        go_on();
        send_bit(1'b1);             // start-up: not stored
        do_tick();
        chk(int'(rx_en), 1, "R4 rx_en after start-up");
        send_bit(1'b1);             // base window: not stored
        chk(int'(fifo_empty), 1, "R7 bits outside extension dropped");
        dqi = 1'b1;
        @(negedge clk);
        chk(int'(irq), 1, "R5 irq after dqi");
        for (int i = 0; i < 12; i++) begin
            do_tick();
            chk(int'(osc_en), 1, "R5 osc_en held by dqi");
            chk(int'(rx_en), 1, "R5 rx_en held by dqi");
        end
        pat = 8'b0110_1101;
        for (int i = 0; i < 5; i++) send_bit(pat[i]);
        dqi = 1'b0;
        @(negedge clk);
        chk(int'(osc_en), 0, "R6 osc_en off after dqi low");
        chk(int'(irq), 0, "R6 irq cleared at sleep");
        for (int i = 1; i <= 7; i++) begin
            do_tick();
            chk(int'(osc_en), (i == 7) ? 1 : 0, "R6 sleep gap P-T");
        end
        send_bit(1'b0);             // start-up again: not stored
        for (int i = 0; i < 5; i++) pop_bit(pat[i], "R7 FIFO order");
        chk(int'(fifo_empty), 1, "R7 empty after reads");
        go_off();

        // R6: host done pulse closes window while dqi still high
        go_on();
        do_tick();
        dqi = 1'b1;
        @(negedge clk);
        chk(int'(irq), 1, "R5 irq second window");
        fifo_done = 1'b1;
        @(negedge clk);
        fifo_done = 1'b0;
        chk(int'(osc_en), 0, "R6 osc_en off after fifo_done");
        chk(int'(irq), 0, "R6 irq cleared after fifo_done");
        dqi = 1'b0;
        go_off();

        // R8 overflow
        go_on();
        do_tick();
        dqi = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 10; i++) send_bit((i % 3) == 0);
        chk(int'(fifo_full), 1, "R8 fifo_full");
        chk(int'(overflow), 1, "R8 overflow set");
        dqi = 1'b0;
        @(negedge clk);
        chk(int'(overflow), 1, "R8 overflow sticky over sleep");
        for (int i = 0; i < 8; i++) pop_bit((i % 3) == 0, "R8 stored bits unchanged");
        chk(int'(fifo_empty), 1, "R8 empty after reads");
        fifo_pop = 1'b1;
        @(negedge clk);
        fifo_pop = 1'b0;
        chk(int'(fifo_empty), 1, "R7 pop on empty ignored");
        send_bit(1'b1);
        chk(int'(fifo_empty), 1, "R7 sleep strobe dropped");
        chk(int'(overflow), 1, "R8 overflow still set");
        go_off();

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule